// File: doc/BRIEF.md
# Processor/DMA Bus Ownership Arbiter

This block decides whether the processor or a DMA engine drives the shared address, data and control buses. The processor owns the buses after reset and keeps them while it fetches and executes. A DMA engine asks for the buses by pulling its active-low hold request low. The arbiter hands the buses over only at a safe point: the processor's current memory cycle must have ended, and the processor must not be holding the bus lock.

The hand-over is seen on two outputs that always move together. `hlda` tells the DMA engine that it now owns the buses. `aen` isolates the processor's address latches and data buffers from the system bus. While `aen` is low, the processor's latched address drives the system bus. While `aen` is high, the processor side is cut off, so another master can use the bus without disturbing it. The hold request can come from another clock domain, so it passes through a synchronizer first. `cycle_done` and `lock` come from the processor's bus interface in the arbiter's own clock domain.

Top module: `bus_own_arbiter`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) drives `hlda` and `aen` low after that edge, whatever the level of `hrq_n`. The processor owns the buses after reset.
- R2: `hlda` and `aen` are equal in every cycle. A value of 1 means the DMA engine owns the buses and the processor side is isolated. A value of 0 means the processor owns them.
- R3: The request is active low. `hrq_n` goes through a synchronizer of SYNC_STAGES flops (default 2). With `cycle_done`=1 and `lock`=0, `hrq_n` driven low before rising edge 1 gives `hlda`=0 after edge 2 and `hlda`=1 after edge 3.
- R4: While `cycle_done` is 0, a pending request is not granted.
- R5: While `lock` is 1, a pending request is not granted.
- R6: Take a rising edge where the processor owns the buses and the synchronized request, `cycle_done`=1 and `lock`=0 all hold. After that edge, `hlda` and `aen` are high.
- R7: When `hrq_n` returns high, the synchronized request drops. `hlda` and `aen` then fall at the next edge. With the default depth, they are low after the third edge that follows the change.
- R8: While the DMA engine owns the buses, `lock` and `cycle_done` have no effect. Ownership is kept as long as the synchronized request stays present.
- R9: A reset applied while the DMA engine owns the buses returns them to the processor after that edge, even if `hrq_n` is still low. After reset is released with the request still held, the request is granted again through the full synchronizer latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hrq_n | input | 1 | Hold request from the DMA engine, active low |
| cycle_done | input | 1 | High when the processor's current memory cycle has ended |
| lock | input | 1 | High while the processor holds the bus lock |
| hlda | output | 1 | Hold acknowledge to the DMA engine |
| aen | output | 1 | Address enable; high isolates the processor from the system bus |

## Verification
The bench measures the exact latency through the synchronizer on the way in and on the way out. A design that skipped a stage, or added one, would grant or release one edge early or late. It holds a request against `lock` and against an unfinished cycle. A design that ignored either guard would take the bus in the middle of a locked sequence or a cycle still in progress. It toggles `lock` and `cycle_done` during DMA ownership, where a design that reused the grant guard for holding would drop the DMA engine in the middle of a transfer. It also resets during DMA ownership with the request still held, which catches synchronizer flops that survive reset and would cause an early re-grant. A long random run is compared edge by edge against a behavioural model.

// File: rtl/bus_own_pkg.sv
// Shared types for the bus ownership arbiter.
package bus_own_pkg;
    // Which master currently drives the shared buses.
    typedef enum logic {
        OWN_CPU = 1'b0,
        OWN_DMA = 1'b1
    } owner_e;
endpackage

// File: rtl/bus_own_sync.sv
// Multi-flop synchronizer for a single control bit.
// Assumes STAGES >= 2. Every stage resets to RST_VAL through the synchronous
// active-low reset.
module bus_own_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] stg;

    genvar i;
    generate
        for (i = 0; i <= LAST; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage: capture the input, which may be asynchronous.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Later stages: let the value settle before it is used.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[LAST];
endmodule

// File: rtl/bus_own_fsm.sv
// Ownership state machine.
// The processor holds the buses until a synchronized request arrives while
// the processor cycle has ended and lock is low. The DMA engine then holds
// them until the synchronized request drops; lock and cycle_done are not
// consulted in that state. Assumes req_s is already in the clk domain.
module bus_own_fsm
    import bus_own_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_s,
    input  logic   cycle_done,
    input  logic   lock,
    output owner_e owner
);
    owner_e state_q, state_d;
    logic   grant_ok;

    // A safe point to hand over: the cycle has ended and the bus is not locked.
    assign grant_ok = req_s && cycle_done && !lock;

    // Choose the next owner.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_CPU: if (grant_ok) state_d = OWN_DMA;
            OWN_DMA: if (!req_s)   state_d = OWN_CPU;
            default: state_d = OWN_CPU;
        endcase
    end

    // Ownership register; reset gives the buses to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OWN_CPU;
        else        state_q <= state_d;
    end

    assign owner = state_q;
endmodule

// File: rtl/bus_own_out.sv
// Output decode. Acknowledge and address enable both come straight from the
// ownership flop, so they change in the same cycle and do not glitch.
module bus_own_out
    import bus_own_pkg::*;
(
    input  owner_e owner,
    output logic   hlda,
    output logic   aen
);
    // Both outputs show DMA ownership.
    always_comb begin
        hlda = (owner == OWN_DMA);
        aen  = (owner == OWN_DMA);
    end
endmodule

// File: rtl/bus_own_arbiter.sv
// Top level of the processor/DMA bus ownership arbiter.
// hrq_n is active low and may be asynchronous; it is inverted and then
// synchronized. cycle_done and lock are assumed to be in the clk domain.
module bus_own_arbiter
    import bus_own_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hrq_n,
    input  logic cycle_done,
    input  logic lock,
    output logic hlda,
    output logic aen
);
    logic   req_raw;
    logic   req_sync;
    owner_e owner;

    // Turn the active-low request into an active-high one.
    assign req_raw = ~hrq_n;

    bus_own_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_raw),
        .q     (req_sync)
    );

    bus_own_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (req_sync),
        .cycle_done (cycle_done),
        .lock       (lock),
        .owner      (owner)
    );

    bus_own_out u_out (
        .owner (owner),
        .hlda  (hlda),
        .aen   (aen)
    );
endmodule

// File: rtl/bus_own_arbiter_chk.sv
// Assertion checker for bus_own_arbiter. It is attached with bind and
// watches the ports together with the synchronized request.
module bus_own_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic cycle_done,
    input logic lock,
    input logic req_s,
    input logic hlda,
    input logic aen
);
    // R1: the first edge after reset is released still shows processor ownership.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!hlda && !aen));

    // R2: acknowledge and address enable never differ.
    a_r2_outputs_match: assert property (@(posedge clk) disable iff (!rst_n)
        hlda == aen);

    // R4 R5: a new grant needs a finished cycle and lock low at the granting edge.
    a_r5_grant_safe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> ($past(cycle_done) && !$past(lock)));

    // R6: a safe request while the processor owns the buses is granted at the next edge.
    a_r6_grant_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!hlda && req_s && cycle_done && !lock) |=> hlda);

    // R7: if the synchronized request is gone during DMA ownership, release at the next edge.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !req_s) |=> !hlda);

    // R8: while the request stays present, DMA ownership is kept whatever lock does.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && req_s) |=> hlda);
endmodule

bind bus_own_arbiter bus_own_arbiter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycle_done (cycle_done),
    .lock       (lock),
    .req_s      (req_sync),
    .hlda       (hlda),
    .aen        (aen)
);

// File: tb/bus_own_arbiter_tb.sv
// Bench for bus_own_arbiter: directed latency checks plus a behavioural
// reference model compared after every rising edge.
module bus_own_arbiter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hrq_n = 1'b1;
    logic cycle_done = 1'b0;
    logic lock = 1'b0;
    logic hlda, aen;

    int    n_run = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string phase = "R1";
    bit    done = 1'b0;

    // Reference model state: queue of request samples, oldest first, and owner.
    bit    req_q[$];
    bit    exp_own = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bus_own_arbiter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hrq_n      (hrq_n),
        .cycle_done (cycle_done),
        .lock       (lock),
        .hlda       (hlda),
        .aen        (aen)
    );

    initial begin
        req_q = '{1'b0, 1'b0};
    end

    // Reference model: reads only the bench's inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_own = 1'b0;
            req_q = '{1'b0, 1'b0};
        end else begin
            if (exp_own) exp_own = req_q[0];
            else         exp_own = req_q[0] && cycle_done && !lock;
            void'(req_q.pop_front());
            req_q.push_back(!hrq_n);
        end
    end

    // Per-edge comparison against the model, away from the edge.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            n_run++;
            if (hlda !== exp_own || aen !== exp_own) begin
                n_fail++;
                $display("FAIL %s model cycle %0d: hlda=%b aen=%b expected %b",
                         phase, cyc, hlda, aen, exp_own);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp || aen !== exp) begin
            n_fail++;
            $display("FAIL %s: hlda=%b aen=%b expected %b", req, act, aen, exp);
        end
    endtask

    // Drive the inputs at the falling edge.
    task automatic drive(input logic h, input logic cd, input logic lk);
        hrq_n = h; cycle_done = cd; lock = lk;
    endtask

    initial begin
        // R1: reset with the request held low.
        phase = "R1";
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0);
        step(4);
        chk("R1", hlda, 1'b0);
        drive(1'b1, 1'b1, 1'b0);
        step(3);                        // clear the synchronizer while still in reset
        rst_n = 1'b1;
        step(3);
        chk("R1", hlda, 1'b0);

        // R3: synchronizer latency on the way in.
        phase = "R3";
        drive(1'b0, 1'b1, 1'b0);
        step(2);
        chk("R3", hlda, 1'b0);
        step(1);
        chk("R3", hlda, 1'b1);
        chk("R2", aen, 1'b1);

        // R7: latency on the way out.
        phase = "R7";
        drive(1'b1, 1'b1, 1'b0);
        step(2);
        chk("R7", hlda, 1'b1);
        step(1);
        chk("R7", hlda, 1'b0);
        step(3);

        // R5: lock blocks a grant; R6: grant comes one edge after lock drops.
        phase = "R5";
        drive(1'b0, 1'b1, 1'b1);
        step(6);
        chk("R5", hlda, 1'b0);
        phase = "R6";
        lock = 1'b0;
        step(1);
        chk("R6", hlda, 1'b1);

        // R8: lock and cycle_done toggled during DMA ownership do nothing.
        phase = "R8";
        drive(1'b0, 1'b0, 1'b1);
        step(3);
        chk("R8", hlda, 1'b1);
        drive(1'b0, 1'b1, 1'b1);
        step(2);
        chk("R8", hlda, 1'b1);
        drive(1'b1, 1'b1, 1'b0);
        step(4);
        chk("R7", hlda, 1'b0);

        // R4: an unfinished cycle blocks the grant.
        phase = "R4";
        drive(1'b0, 1'b0, 1'b0);
        step(6);
        chk("R4", hlda, 1'b0);
        cycle_done = 1'b1;
        step(1);
        chk("R6", hlda, 1'b1);

        // R9: reset during DMA ownership with the request still held.
        phase = "R9";
        rst_n = 1'b0;
        step(1);
        chk("R9", hlda, 1'b0);
        rst_n = 1'b1;
        step(2);
        chk("R9", hlda, 1'b0);
        step(1);
        chk("R9", hlda, 1'b1);

        // R2 R6 R7 R8: random traffic checked against the model.
        phase = "R2";
        for (int i = 0; i < 3000; i++) begin
            drive(1'($urandom_range(0, 3) == 0 ? ~hrq_n : hrq_n),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
            step(1);
        end
        drive(1'b1, 1'b0, 1'b0);
        step(4);
        chk("R7", hlda, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule